// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Carry and Zero Flags

This block is the arithmetic heart of a small accumulator machine. One operand always comes from the accumulator. The other comes from a general register or from an immediate field that the surrounding datapath has already selected. A four-bit operation select picks the function, and its values match the opcode field of the instruction word, so the controller can route opcode bits straight to the unit.

The unit has no clock and no state. It returns an eight-bit result together with two flag values, carry and zero, in the same cycle. The datapath decides whether to write the result into the accumulator and whether to capture the flags. Carry has a different meaning for each operation:

- For addition it is the carry out of the top bit.
- For subtraction it signals a borrow.
- For shifts it holds the bit that falls off the end.

Selects that name no arithmetic function return the accumulator operand unchanged with carry clear. This means instructions such as stores, jumps and no-ops leave the accumulator value intact when the result is written back.

Top module: `accum_alu`

## Requirements
- R1: Select 4'b0001 yields result = (A + B) mod 256, and carry equals the carry out of bit 7 of that sum.
- R2: Select 4'b0010 yields result = (A - B) mod 256, and carry is 1 exactly when B is greater than A (unsigned).
- R3: Select 4'b0011 yields result = bitwise NOT of (A OR B), with carry 0.
- R4: Selects 4'b0100 (register move) and 4'b1101 (immediate load) both yield result = B, with carry 0.
- R5: Select 4'b1011 yields A shifted left by one with bit 0 filled with 0, and carry equals the old A bit 7.
- R6: Select 4'b1100 yields A shifted right by one with bit 7 filled with 0, and carry equals the old A bit 0.
- R7: For every select value, zero is 1 exactly when the 8-bit result is all zeros.
- R8: Every other select value (0000, 0101 through 1010, 1110, 1111) yields result = A, with carry 0.
- R9: The outputs depend only on the present inputs. A change of any input is reflected at the outputs before the next clock edge, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a_i | input | 8 | Accumulator operand A |
| opnd_b_i | input | 8 | Register or immediate operand B |
| op_sel_i | input | 4 | Operation select, same encoding as the instruction opcode |
| result_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| zero_o | output | 1 | High when result is zero |

## Verification
The bound checker re-evaluates the unit on every input change. For each select it checks the carry and borrow relations, the fill bits of both shifts, the pass-through and default results, and the zero flag against an independently known operand on pass-through.

The zero flag over all functions, the exact wrap-around of subtraction, and the absence of any latency can only be shown by the bench. The bench drives directed corner operands (0x00, 0xFF, equal operands, B one above A) and a sweep of operand pairs across all sixteen selects. Each vector is compared with a behavioural model half a clock after it is driven.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    // Operation select codes; values equal the instruction opcode field.
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD   = 4'b0001,
        OP_SUB   = 4'b0010,
        OP_NOR   = 4'b0011,
        OP_MOVB  = 4'b0100,
        OP_SHL   = 4'b1011,
        OP_SHR   = 4'b1100,
        OP_LDIMM = 4'b1101
    } alu_op_e;

    function automatic logic is_pass_b(input logic [SEL_W-1:0] sel);
        return (sel == OP_MOVB) || (sel == OP_LDIMM);
    endfunction

endpackage

// File: rtl/accum_alu_arith.sv
// Shared adder/subtractor: one extended-width datapath produces either the
// sum with carry out, or the difference with borrow in the top bit.
module accum_alu_arith #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int unsigned EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] ext_d;

    always_comb begin
        a_ext = {1'b0, a_i};
        b_ext = {1'b0, b_i};
        if (sub_i) begin
            ext_d = a_ext - b_ext;
        end else begin
            ext_d = a_ext + b_ext;
        end
    end

    assign res_o  = ext_d[WIDTH-1:0];
    assign cout_o = ext_d[EXT_W-1];

endmodule

// File: rtl/accum_alu_shift.sv
// One-bit logical shifter; TO_LEFT picks the direction at elaboration.
module accum_alu_shift #(
    parameter int unsigned WIDTH   = 8,
    parameter bit          TO_LEFT = 1'b1
) (
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] res_o,
    output logic             out_bit_o
);
    generate
        if (TO_LEFT) begin : g_left
            assign res_o     = {a_i[WIDTH-2:0], 1'b0};
            assign out_bit_o = a_i[WIDTH-1];
        end else begin : g_right
            assign res_o     = {1'b0, a_i[WIDTH-1:1]};
            assign out_bit_o = a_i[0];
        end
    endgenerate

endmodule

// File: rtl/accum_alu_logic.sv
// Bitwise NOR of the two operands.
module accum_alu_logic #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign res_o[i] = ~(a_i[i] | b_i[i]);
        end
    endgenerate

endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a_i,
    input  logic [WIDTH-1:0] opnd_b_i,
    input  logic [SEL_W-1:0] op_sel_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             c;
    } alu_out_t;

    localparam int unsigned N_SHIFT = 2;

    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic             do_sub;
    logic [WIDTH-1:0] nor_res;
    logic [WIDTH-1:0] sh_res [N_SHIFT];
    logic             sh_c   [N_SHIFT];
    alu_out_t         out_d;

    assign do_sub = (op_sel_i == OP_SUB);

    accum_alu_arith #(.WIDTH(WIDTH)) arith_i (
        .a_i    (opnd_a_i),
        .b_i    (opnd_b_i),
        .sub_i  (do_sub),
        .res_o  (arith_res),
        .cout_o (arith_c)
    );

    accum_alu_logic #(.WIDTH(WIDTH)) logic_i (
        .a_i   (opnd_a_i),
        .b_i   (opnd_b_i),
        .res_o (nor_res)
    );

    // Index 0 shifts left, index 1 shifts right.
    generate
        for (genvar s = 0; s < N_SHIFT; s++) begin : g_shift
            accum_alu_shift #(.WIDTH(WIDTH), .TO_LEFT(s == 0)) shift_i (
                .a_i       (opnd_a_i),
                .res_o     (sh_res[s]),
                .out_bit_o (sh_c[s])
            );
        end
    endgenerate

    always_comb begin
        out_d.res = opnd_a_i;
        out_d.c   = 1'b0;
        case (op_sel_i)
            OP_ADD, OP_SUB: begin
                out_d.res = arith_res;
                out_d.c   = arith_c;
            end
            OP_NOR: begin
                out_d.res = nor_res;
            end
            OP_MOVB, OP_LDIMM: begin
                out_d.res = opnd_b_i;
            end
            OP_SHL: begin
                out_d.res = sh_res[0];
                out_d.c   = sh_c[0];
            end
            OP_SHR: begin
                out_d.res = sh_res[1];
                out_d.c   = sh_c[1];
            end
            default: begin
                out_d.res = opnd_a_i;
                out_d.c   = 1'b0;
            end
        endcase
    end

    assign result_o = out_d.res;
    assign carry_o  = out_d.c;
    assign zero_o   = ~|out_d.res;

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
    import accum_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_a_i,
    input logic [WIDTH-1:0] opnd_b_i,
    input logic [SEL_W-1:0] op_sel_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             zero_o
);
    logic [WIDTH:0] full_sum;
    logic           known;
    logic           is_other;

    always_comb begin
        full_sum = {1'b0, opnd_a_i} + {1'b0, opnd_b_i};
        known    = !$isunknown({opnd_a_i, opnd_b_i, op_sel_i, result_o, carry_o, zero_o});
        is_other = !(op_sel_i inside {OP_ADD, OP_SUB, OP_NOR, OP_MOVB, OP_SHL, OP_SHR, OP_LDIMM});

        if (known) begin
            if (op_sel_i == OP_ADD) begin
                a_r1_add_sum: assert ({carry_o, result_o} == full_sum)
                    else $error("R1 add result/carry mismatch");
            end
            if (op_sel_i == OP_SUB) begin
                a_r2_sub_borrow: assert (carry_o == (opnd_b_i > opnd_a_i))
                    else $error("R2 borrow mismatch");
                a_r2_sub_inverse: assert (result_o + opnd_b_i == opnd_a_i)
                    else $error("R2 difference mismatch");
            end
            if (op_sel_i == OP_NOR) begin
                a_r3_nor_disjoint: assert (!carry_o && ((result_o & (opnd_a_i | opnd_b_i)) == '0)
                                           && ((result_o | opnd_a_i | opnd_b_i) == '1))
                    else $error("R3 nor mismatch");
            end
            if (is_pass_b(op_sel_i)) begin
                a_r4_pass_b: assert (result_o == opnd_b_i && !carry_o)
                    else $error("R4 pass-through mismatch");
                a_r7_zero_pass: assert (zero_o == (opnd_b_i == '0))
                    else $error("R7 zero flag mismatch on pass-through");
            end
            if (op_sel_i == OP_SHL) begin
                a_r5_shl_edge: assert (carry_o == opnd_a_i[WIDTH-1] && !result_o[0]
                                       && result_o[WIDTH-1:1] == opnd_a_i[WIDTH-2:0])
                    else $error("R5 shift-left mismatch");
            end
            if (op_sel_i == OP_SHR) begin
                a_r6_shr_edge: assert (carry_o == opnd_a_i[0] && !result_o[WIDTH-1]
                                       && result_o[WIDTH-2:0] == opnd_a_i[WIDTH-1:1])
                    else $error("R6 shift-right mismatch");
            end
            if (is_other) begin
                a_r8_hold_a: assert (result_o == opnd_a_i && !carry_o)
                    else $error("R8 default select mismatch");
            end
        end
    end

endmodule

bind accum_alu accum_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .opnd_a_i (opnd_a_i),
    .opnd_b_i (opnd_b_i),
    .op_sel_i (op_sel_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .zero_o   (zero_o)
);

// File: tb/accum_alu_tb_top.sv
module accum_alu_tb_top;

    logic       clk;
    logic       rst_n;
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] sel;
    logic [7:0] res;
    logic       cy;
    logic       zf;

    int n_vec;
    int n_bad;
    bit done;

    accum_alu dut_i (
        .opnd_a_i (a),
        .opnd_b_i (b),
        .op_sel_i (sel),
        .result_o (res),
        .carry_o  (cy),
        .zero_o   (zf)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Behavioural reference: returns {zero, carry, result}.
    function automatic logic [9:0] model(input int op, input int av, input int bv);
        int r;
        int c;
        r = av;
        c = 0;
        case (op)
            1:  begin r = av + bv; c = (r > 255) ? 1 : 0; end
            2:  begin r = av - bv; c = (bv > av) ? 1 : 0; end
            3:  r = 255 - (av | bv);
            4, 13: r = bv;
            11: begin c = av / 128; r = av * 2; end
            12: begin c = av % 2; r = av / 2; end
            default: r = av;
        endcase
        r = r & 255;
        return {logic'(r == 0), logic'(c[0]), 8'(r)};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4, 13: return "R4";
            11: return "R5";
            12: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Drive after a rising edge, compare at the following falling edge (R9).
    task automatic apply(input int op, input int av, input int bv);
        logic [9:0] exp;
        @(posedge clk);
        sel = 4'(op);
        a   = 8'(av);
        b   = 8'(bv);
        @(negedge clk);
        exp = model(op, av, bv);
        n_vec++;
        if ({cy, res} != exp[8:0]) begin
            n_bad++;
            $display("FAIL %s/R9 op=%0d a=%02h b=%02h got c=%0b r=%02h exp c=%0b r=%02h",
                     tag_of(op), op, av, bv, cy, res, exp[8], exp[7:0]);
        end
        n_vec++;
        if (zf != exp[9]) begin
            n_bad++;
            $display("FAIL R7 op=%0d a=%02h b=%02h got z=%0b exp z=%0b",
                     op, av, bv, zf, exp[9]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    int corner[$] = '{0, 1, 2, 4, 8'h7f, 8'h80, 8'hfe, 8'hff, 8'h55, 8'haa};

    initial begin
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        a = '0;
        b = '0;
        sel = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Quiet state: all-zero inputs give zero result, zero flag set (R8, R7).
        @(negedge clk);
        n_vec++;
        if (res !== 8'h00 || cy !== 1'b0 || zf !== 1'b1) begin
            n_bad++;
            $display("FAIL R8 idle got r=%02h c=%0b z=%0b exp r=00 c=0 z=1", res, cy, zf);
        end

        // Directed corners.
        apply(1, 8'hff, 8'h01);   // R1 wrap to zero with carry
        apply(1, 8'h7f, 8'h01);   // R1 no carry
        apply(2, 2, 4);           // R2 borrow, result FE
        apply(2, 4, 4);           // R2 equal -> zero, no borrow
        apply(2, 4, 5);           // R2 B one above A
        apply(2, 0, 8'hff);       // R2 maximal borrow
        apply(3, 8'h00, 8'h00);   // R3 all ones
        apply(3, 8'hf0, 8'h0f);   // R3 zero result
        apply(4, 8'h33, 8'h00);   // R4 pass zero
        apply(13, 8'h00, 8'h0d);  // R4 immediate
        apply(11, 8'h80, 0);      // R5 carry out, zero result
        apply(11, 8'h49, 0);      // R5
        apply(12, 8'h01, 0);      // R6 carry out, zero result
        apply(12, 8'h92, 0);      // R6
        apply(0, 8'h5a, 8'hff);   // R8 no-op keeps A
        apply(15, 8'h00, 8'hff);  // R8 zero A on halt code

        // Sweep: every select across corner operand pairs.
        for (int op = 0; op < 16; op++) begin
            foreach (corner[i]) begin
                foreach (corner[j]) begin
                    apply(op, corner[i], corner[j]);
                end
            end
        end

        // Back-to-back changes within consecutive cycles (R9).
        for (int k = 0; k < 256; k++) begin
            apply(k % 16, (k * 37 + 11) & 255, (k * 91 + 3) & 255);
        end

        finish_run();
    end

endmodule